// File: doc/BRIEF.md
# Tuner Bank Packet Interleaver

This block collects the output samples of a group of narrowband tuner channels that share one decimation rate and one start/stop control, and merges them into a single output stream. Each channel feeds its own small FIFO. The block then sends a fixed-length packet from channel 1, a packet from channel 2, and so on up to the last active channel, and then starts again at channel 1. Every output word carries a start-of-packet flag and the 1-based index of the channel it came from. A downstream DMA engine can therefore lay out the buffer without any extra framing.

A settings path holds the frequency and gain of each channel. A selector value of zero writes the same value to every channel, and a nonzero selector writes one channel. In spaced mode, the channel frequencies come from one base value plus a multiple of a spacing. A write to the base then moves the whole group, and single-channel frequency writes are refused.

The packet length and the active channel count are captured when the bank is started.

Top module: `tbank_interleaver`

## Requirements
- R1: After reset, `outValid`, `outSop`, `outChan`, `outData`, `running` and `overflowErr` are zero, and every frequency and gain output is zero.
- R2: While running, output words come in packets of the latched length. The channel order is 1, 2, …, up to the active count, and then wraps back to 1. `outChan` is 1-based, and `outSop` is 1 only on the first word of each packet.
- R3: Words from one channel leave in arrival order. If the current channel has no data, the output waits for that channel and never skips ahead to another one.
- R4: A start pulse latches `cfgPktLen` and `cfgChanCount`. A length of 0 is taken as 1. A count of 0, or a count above the channel total, is taken as the channel total. Changes to these inputs while running have no effect.
- R5: Samples offered on a channel whose 1-based index is above the active count are ignored. That channel never appears on the output and never raises an overflow.
- R6: A sample that arrives at a full FIFO is dropped and sets `overflowErr`, which stays set until the next start. The order of the remaining words is unchanged.
- R7: A start pulse empties every FIFO and restarts the order at channel 1 and word 0. A stop pulse clears `running`, and after it no further input is accepted and no further output is produced.
- R8: A gain write (`setIsGain`=1) with `setSel`=0 sets every channel's gain. With `setSel`=k in 1..N it sets only channel k. Any larger selector changes nothing.
- R9: When spaced mode is off, a frequency write (`setIsGain`=0) follows the same selector rule as R8, and each channel shows its own stored frequency.
- R10: When spaced mode is on, channel k shows base + (k−1)×`chanSpacing`, where a frequency write with `setSel`=0 sets the base. Frequency writes with a nonzero selector change nothing, and the stored per-channel values come back when spaced mode is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse: latch config, flush FIFOs, run |
| stopReq | input | 1 | Stop pulse |
| cfgPktLen | input | LEN_W | Words per packet |
| cfgChanCount | input | CH_W | Active channel count |
| inValid | input | NUM_CH | Per-channel sample strobe |
| inData | input | NUM_CH*DATA_W | Per-channel sample, channel i at bits i*DATA_W |
| outValid | output | 1 | Output word valid |
| outSop | output | 1 | First word of a packet |
| outChan | output | CH_W | 1-based source channel |
| outData | output | DATA_W | Output word |
| running | output | 1 | Bank is running |
| overflowErr | output | 1 | Sticky FIFO overflow flag |
| setWe | input | 1 | Settings write strobe |
| setSel | input | CH_W | Channel selector, 0 means all channels |
| setIsGain | input | 1 | 1 = gain write, 0 = frequency write |
| setValue | input | FREQ_W | Write value (the gain uses the low GAIN_W bits) |
| spacedMode | input | 1 | Equally spaced frequency mode |
| chanSpacing | input | FREQ_W | Spacing between adjacent channels |
| chFreq | output | NUM_CH*FREQ_W | Per-channel frequency |
| chGain | output | NUM_CH*GAIN_W | Per-channel gain |

## Verification
The hardest condition to reach is an overflow that leaves the packet order intact. In normal flow, the channel being drained keeps its FIFO near empty. The stimulus therefore starves channel 1, so the sequencer stalls on it, and pours more than a FIFO's depth into channel 2. It then feeds channel 1 and checks that exactly the first DEPTH words of channel 2 come out, interleaved in correct packets. A second hard case is a restart with stale data still queued. The bench leaves words in a stalled channel, starts the bank again, and checks that only the new words appear.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  localparam int IDX_BITS = 8;

  typedef struct packed {
    logic                flush;
    logic                accept;
    logic                pop;
    logic                sop;
    logic [IDX_BITS-1:0] popIdx;
    logic [IDX_BITS:0]   chanCount;
  } tbank_strobe_t;
endpackage

// File: rtl/tbank_ctrl.sv
module tbank_ctrl
  import tbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 8,
  parameter int FREQ_W = 24,
  parameter int GAIN_W = 8,
  parameter int CH_W   = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic                     stopReq,
  input  logic [LEN_W-1:0]         cfgPktLen,
  input  logic [CH_W-1:0]          cfgChanCount,
  input  logic [NUM_CH-1:0]        notEmpty,
  output tbank_strobe_t            strobe,
  output logic                     running,
  input  logic                     setWe,
  input  logic [CH_W-1:0]          setSel,
  input  logic                     setIsGain,
  input  logic [FREQ_W-1:0]        setValue,
  input  logic                     spacedMode,
  input  logic [FREQ_W-1:0]        chanSpacing,
  output logic [NUM_CH*FREQ_W-1:0] chFreq,
  output logic [NUM_CH*GAIN_W-1:0] chGain
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [LEN_W-1:0] pktLenQ;
  logic [LEN_W-1:0] wordCnt;
  logic [CH_W-1:0]  countQ;
  logic [IDX_W-1:0] curCh;
  logic [CH_W-1:0]  curChExt;
  logic             popNow;
  logic             lastWord;
  logic             lastCh;

  assign curChExt = CH_W'(curCh);
  assign lastWord = (wordCnt + LEN_W'(1)) == pktLenQ;
  assign lastCh   = (curChExt + CH_W'(1)) == countQ;
  assign popNow   = running && !startReq && !stopReq && notEmpty[curCh];

  always_comb begin
    strobe.flush     = startReq;
    strobe.accept    = running && !startReq && !stopReq;
    strobe.pop       = popNow;
    strobe.sop       = (wordCnt == '0);
    strobe.popIdx    = IDX_BITS'(curCh);
    strobe.chanCount = (IDX_BITS + 1)'(countQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      pktLenQ <= LEN_W'(1);
      countQ  <= CH_W'(NUM_CH);
      curCh   <= '0;
      wordCnt <= '0;
    end else if (startReq) begin
      running <= 1'b1;
      pktLenQ <= (cfgPktLen == '0) ? LEN_W'(1) : cfgPktLen;
      countQ  <= (cfgChanCount == '0 || cfgChanCount > CH_W'(NUM_CH)) ? CH_W'(NUM_CH) : cfgChanCount;
      curCh   <= '0;
      wordCnt <= '0;
    end else if (stopReq) begin
      running <= 1'b0;
    end else if (popNow) begin
      if (lastWord) begin
        wordCnt <= '0;
        curCh   <= lastCh ? '0 : curCh + IDX_W'(1);
      end else begin
        wordCnt <= wordCnt + LEN_W'(1);
      end
    end
  end

  // settings: per-channel gain/frequency, base for spaced mode
  logic [GAIN_W-1:0] gainReg [NUM_CH];
  logic [FREQ_W-1:0] freqReg [NUM_CH];
  logic [FREQ_W-1:0] baseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      for (int k = 0; k < NUM_CH; k++) begin
        gainReg[k] <= '0;
        freqReg[k] <= '0;
      end
    end else if (setWe) begin
      if (setIsGain) begin
        for (int k = 0; k < NUM_CH; k++)
          if (setSel == '0 || setSel == CH_W'(k + 1)) gainReg[k] <= setValue[GAIN_W-1:0];
      end else if (spacedMode) begin
        if (setSel == '0) baseQ <= setValue;
      end else begin
        for (int k = 0; k < NUM_CH; k++)
          if (setSel == '0 || setSel == CH_W'(k + 1)) freqReg[k] <= setValue;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_set
    assign chGain[g*GAIN_W +: GAIN_W] = gainReg[g];
    assign chFreq[g*FREQ_W +: FREQ_W] = spacedMode ? (baseQ + FREQ_W'(g) * chanSpacing) : freqReg[g];
  end

  // R4: latched configuration holds for a whole run
  assert_cfg_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$past(startReq)) |-> ($stable(pktLenQ) && $stable(countQ)));

  // R2: word counter never reaches the packet length
  assert_word_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (wordCnt < pktLenQ));

  // R2: current channel stays inside the active set
  assert_chan_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (curChExt < countQ));
endmodule

// File: rtl/tbank_datapath.sv
module tbank_datapath
  import tbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CH_W   = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tbank_strobe_t            strobe,
  input  logic [NUM_CH-1:0]        inValid,
  input  logic [NUM_CH*DATA_W-1:0] inData,
  output logic [NUM_CH-1:0]        notEmpty,
  output logic                     outValid,
  output logic                     outSop,
  output logic [CH_W-1:0]          outChan,
  output logic [DATA_W-1:0]        outData,
  output logic                     overflowErr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [DATA_W-1:0] headData [NUM_CH];
  logic [NUM_CH-1:0] ovfHit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_fifo
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [CNT_W-1:0]  cnt;
    logic pushReq, full, doPush, doPop;

    assign pushReq = strobe.accept && inValid[g] && ((IDX_BITS + 1)'(g) < strobe.chanCount);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign doPush  = pushReq && !full;
    assign doPop   = strobe.pop && (strobe.popIdx == IDX_BITS'(g));
    assign ovfHit[g]   = pushReq && full;
    assign notEmpty[g] = (cnt != '0);
    assign headData[g] = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= inData[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (doPush) wrPtr <= wrPtr + PTR_W'(1);
        if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
        case ({doPush, doPop})
          2'b10:   cnt <= cnt + CNT_W'(1);
          2'b01:   cnt <= cnt - CNT_W'(1);
          default: cnt <= cnt;
        endcase
      end
    end

    // R6: occupancy never exceeds the FIFO depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CNT_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outSop      <= 1'b0;
      outChan     <= '0;
      outData     <= '0;
      overflowErr <= 1'b0;
    end else begin
      outValid <= strobe.pop;
      if (strobe.pop) begin
        outSop  <= strobe.sop;
        outChan <= CH_W'(strobe.popIdx) + CH_W'(1);
        outData <= headData[strobe.popIdx[IDX_W-1:0]];
      end else begin
        outSop <= 1'b0;
      end
      if (strobe.flush)   overflowErr <= 1'b0;
      else if (|ovfHit)   overflowErr <= 1'b1;
    end
  end

  // R6: error flag only clears through a start
  assert_sticky_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(overflowErr) && !$past(strobe.flush)) |-> overflowErr);

  // R7: output only follows a cycle in which the bank was accepting
  assert_out_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.accept));

  // R5: output channel lies within the active set
  assert_out_chan_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outChan != '0 && (IDX_BITS + 1)'(outChan) <= strobe.chanCount));
endmodule

// File: rtl/tbank_interleaver.sv
module tbank_interleaver
  import tbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 8,
  parameter int FREQ_W = 24,
  parameter int GAIN_W = 8,
  localparam int CH_W  = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic                     stopReq,
  input  logic [LEN_W-1:0]         cfgPktLen,
  input  logic [CH_W-1:0]          cfgChanCount,
  input  logic [NUM_CH-1:0]        inValid,
  input  logic [NUM_CH*DATA_W-1:0] inData,
  output logic                     outValid,
  output logic                     outSop,
  output logic [CH_W-1:0]          outChan,
  output logic [DATA_W-1:0]        outData,
  output logic                     running,
  output logic                     overflowErr,
  input  logic                     setWe,
  input  logic [CH_W-1:0]          setSel,
  input  logic                     setIsGain,
  input  logic [FREQ_W-1:0]        setValue,
  input  logic                     spacedMode,
  input  logic [FREQ_W-1:0]        chanSpacing,
  output logic [NUM_CH*FREQ_W-1:0] chFreq,
  output logic [NUM_CH*GAIN_W-1:0] chGain
);
  tbank_strobe_t     strobe;
  logic [NUM_CH-1:0] notEmpty;

  tbank_ctrl #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .FREQ_W(FREQ_W), .GAIN_W(GAIN_W), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .cfgPktLen(cfgPktLen), .cfgChanCount(cfgChanCount), .notEmpty(notEmpty),
    .strobe(strobe), .running(running),
    .setWe(setWe), .setSel(setSel), .setIsGain(setIsGain), .setValue(setValue),
    .spacedMode(spacedMode), .chanSpacing(chanSpacing), .chFreq(chFreq), .chGain(chGain)
  );

  tbank_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(DEPTH), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inValid(inValid), .inData(inData),
    .notEmpty(notEmpty), .outValid(outValid), .outSop(outSop), .outChan(outChan),
    .outData(outData), .overflowErr(overflowErr)
  );
endmodule

// File: tb/tbank_interleaver_tb.sv
module tbank_interleaver_tb;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int LEN_W  = 8;
  localparam int FREQ_W = 24;
  localparam int GAIN_W = 8;
  localparam int CH_W   = $clog2(NUM_CH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, stopReq = 1'b0;
  logic [LEN_W-1:0] cfgPktLen = '0;
  logic [CH_W-1:0] cfgChanCount = '0;
  logic [NUM_CH-1:0] inValid = '0;
  logic [NUM_CH*DATA_W-1:0] inData = '0;
  logic outValid, outSop, running, overflowErr;
  logic [CH_W-1:0] outChan;
  logic [DATA_W-1:0] outData;
  logic setWe = 1'b0, setIsGain = 1'b0, spacedMode = 1'b0;
  logic [CH_W-1:0] setSel = '0;
  logic [FREQ_W-1:0] setValue = '0, chanSpacing = '0;
  logic [NUM_CH*FREQ_W-1:0] chFreq;
  logic [NUM_CH*GAIN_W-1:0] chGain;

  always #4 clk = ~clk;

  tbank_interleaver #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W),
                      .FREQ_W(FREQ_W), .GAIN_W(GAIN_W)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .cfgPktLen(cfgPktLen), .cfgChanCount(cfgChanCount), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outSop(outSop), .outChan(outChan), .outData(outData),
    .running(running), .overflowErr(overflowErr),
    .setWe(setWe), .setSel(setSel), .setIsGain(setIsGain), .setValue(setValue),
    .spacedMode(spacedMode), .chanSpacing(chanSpacing), .chFreq(chFreq), .chGain(chGain)
  );

  int total = 0, bad = 0;
  int gotN = 0, expN = 0;
  logic [DATA_W-1:0] gotData [64];
  logic [CH_W-1:0]   gotChan [64];
  logic              gotSop  [64];
  logic [DATA_W-1:0] expData [64];
  logic [CH_W-1:0]   expChan [64];
  logic              expSop  [64];

  always @(negedge clk) begin
    if (rstN && outValid && gotN < 64) begin
      gotData[gotN] = outData;
      gotChan[gotN] = outChan;
      gotSop[gotN]  = outSop;
      gotN++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word(input int ch, input int seq);
    return {4'(ch), 12'(seq)};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearLog();
    gotN = 0;
    expN = 0;
  endtask

  task automatic expect1(input int ch, input int seq, input bit sop);
    expData[expN] = word(ch, seq);
    expChan[expN] = CH_W'(ch);
    expSop[expN]  = sop;
    expN++;
  endtask

  task automatic compareLog(input string req);
    chk(gotN == expN, req, "word count", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      chk(gotData[i] == expData[i], req, $sformatf("data[%0d]", i), gotData[i], expData[i]);
      chk(gotChan[i] == expChan[i], req, $sformatf("chan[%0d]", i), gotChan[i], expChan[i]);
      chk(gotSop[i] == expSop[i], req, $sformatf("sop[%0d]", i), gotSop[i], expSop[i]);
    end
  endtask

  task automatic startBank(input int len, input int cnt);
    @(negedge clk);
    cfgPktLen = LEN_W'(len);
    cfgChanCount = CH_W'(cnt);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic stopBank();
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic push(input logic [NUM_CH-1:0] mask, input int seq0, input int n);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      inValid = mask;
      for (int c = 0; c < NUM_CH; c++) inData[c*DATA_W +: DATA_W] = word(c + 1, seq0 + s);
    end
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic writeSet(input bit isGain, input int sel, input int value);
    @(negedge clk);
    setWe = 1'b1;
    setIsGain = isGain;
    setSel = CH_W'(sel);
    setValue = FREQ_W'(value);
    @(negedge clk);
    setWe = 1'b0;
  endtask

  task automatic testReset();
    chk(outValid == 0 && outSop == 0 && outChan == 0 && outData == 0, "R1", "outputs idle",
        {outValid, outSop, outChan, outData}, 0);
    chk(running == 0 && overflowErr == 0, "R1", "running/err", {running, overflowErr}, 0);
    chk(chFreq == '0 && chGain == '0, "R1", "settings zero", chGain, 0);
  endtask

  // R2 round-robin with 3 of 4 channels; R5 channel 4 ignored
  task automatic testRoundRobin();
    startBank(2, 3);
    clearLog();
    push(4'b1111, 16, 4);
    cycles(20);
    for (int r = 0; r < 2; r++)
      for (int c = 1; c <= 3; c++) begin
        expect1(c, 16 + 2*r, 1'b1);
        expect1(c, 17 + 2*r, 1'b0);
      end
    compareLog("R2");
    chk(overflowErr == 0, "R5", "no overflow from inactive ch", overflowErr, 0);
    stopBank();
  endtask

  // R3 sequencer waits on empty channel 1
  task automatic testWait();
    startBank(3, 2);
    clearLog();
    push(4'b0010, 32, 3);
    cycles(10);
    chk(gotN == 0, "R3", "no output while ch1 empty", gotN, 0);
    push(4'b0001, 48, 3);
    cycles(12);
    for (int i = 0; i < 3; i++) expect1(1, 48 + i, i == 0);
    for (int i = 0; i < 3; i++) expect1(2, 32 + i, i == 0);
    compareLog("R3");
    stopBank();
  endtask

  // R4 len 0 -> 1, count 0 -> all, cfg changes while running ignored
  task automatic testLatch();
    startBank(0, 0);
    clearLog();
    cfgPktLen = LEN_W'(5);
    cfgChanCount = CH_W'(1);
    push(4'b1111, 64, 2);
    cycles(15);
    for (int s = 0; s < 2; s++)
      for (int c = 1; c <= 4; c++) expect1(c, 64 + s, 1'b1);
    compareLog("R4");
    stopBank();
  endtask

  // R6 overflow on a stalled channel, order kept
  task automatic testOverflow();
    startBank(2, 2);
    clearLog();
    push(4'b0010, 80, DEPTH + 2);
    chk(overflowErr == 1, "R6", "sticky flag set", overflowErr, 1);
    chk(gotN == 0, "R6", "no output during stall", gotN, 0);
    push(4'b0001, 96, DEPTH);
    cycles(25);
    for (int r = 0; r < DEPTH/2; r++) begin
      expect1(1, 96 + 2*r, 1'b1);
      expect1(1, 97 + 2*r, 1'b0);
      expect1(2, 80 + 2*r, 1'b1);
      expect1(2, 81 + 2*r, 1'b0);
    end
    compareLog("R6");
    chk(overflowErr == 1, "R6", "flag still set", overflowErr, 1);
    stopBank();
  endtask

  // R7 restart flushes stale data and clears error; stop halts
  task automatic testRestartStop();
    startBank(2, 2);
    chk(overflowErr == 0, "R7", "start clears error", overflowErr, 0);
    clearLog();
    push(4'b0010, 112, 3);
    cycles(4);
    startBank(2, 2);
    push(4'b0011, 128, 2);
    cycles(12);
    expect1(1, 128, 1'b1); expect1(1, 129, 1'b0);
    expect1(2, 128, 1'b1); expect1(2, 129, 1'b0);
    compareLog("R7");
    stopBank();
    chk(running == 0, "R7", "running cleared by stop", running, 0);
    clearLog();
    push(4'b0011, 144, 2);
    cycles(10);
    chk(gotN == 0, "R7", "no output after stop", gotN, 0);
  endtask

  task automatic testSettings();
    writeSet(1'b1, 0, 'h33);
    for (int c = 0; c < NUM_CH; c++)
      chk(chGain[c*GAIN_W +: GAIN_W] == 8'h33, "R8", $sformatf("broadcast gain ch%0d", c + 1),
          chGain[c*GAIN_W +: GAIN_W], 'h33);
    writeSet(1'b1, 2, 'h5A);
    writeSet(1'b1, 7, 'h11);
    for (int c = 0; c < NUM_CH; c++)
      chk(chGain[c*GAIN_W +: GAIN_W] == ((c == 1) ? 8'h5A : 8'h33), "R8",
          $sformatf("single gain ch%0d", c + 1), chGain[c*GAIN_W +: GAIN_W], (c == 1) ? 'h5A : 'h33);
    writeSet(1'b0, 0, 100);
    writeSet(1'b0, 3, 777);
    for (int c = 0; c < NUM_CH; c++)
      chk(chFreq[c*FREQ_W +: FREQ_W] == ((c == 2) ? 777 : 100), "R9",
          $sformatf("freq ch%0d", c + 1), chFreq[c*FREQ_W +: FREQ_W], (c == 2) ? 777 : 100);
    @(negedge clk);
    chanSpacing = FREQ_W'(10);
    spacedMode = 1'b1;
    writeSet(1'b0, 0, 1000);
    writeSet(1'b0, 2, 5);
    for (int c = 0; c < NUM_CH; c++)
      chk(chFreq[c*FREQ_W +: FREQ_W] == FREQ_W'(1000 + 10*c), "R10",
          $sformatf("spaced ch%0d", c + 1), chFreq[c*FREQ_W +: FREQ_W], 1000 + 10*c);
    @(negedge clk);
    spacedMode = 1'b0;
    @(negedge clk);
    chk(chFreq[2*FREQ_W +: FREQ_W] == 777 && chFreq[1*FREQ_W +: FREQ_W] == 100, "R10",
        "stored freqs back", chFreq[2*FREQ_W +: FREQ_W], 777);
  endtask

  bit finished = 1'b0;

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    testReset();
    testRoundRobin();
    testWait();
    testLatch();
    testOverflow();
    testRestartStop();
    testSettings();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule